// File: doc/BRIEF.md
# Clock Synchronizer Mode Sequencer

This block decides which operating mode a digital clock synchronizer is in and drives the status and enable signals that go with each mode. It runs from the 20 MHz master clock. After the active-low reset input is released, it keeps the synchronizer in a timed start-up hold of 3 ms. During that hold the clock and frame-pulse drivers are disabled, so the external tri-state buffers float their pins. After the hold it passes through freerun. From then on it moves between freerun and reference tracking on its own, following the reference-fail flag from the reference monitor. No software is involved.

Three inputs arrive from other clock domains: the reset release, the reference-fail flag and the raw lock flag from the phase detector. Each is brought onto the master clock through a two-flop synchronizer before it is used. The lock indicator is qualified. It rises only after the raw lock flag has stayed high for a programmable run of cycles while the block is tracking the reference. It is forced low in every other mode.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs show the start-up state in the same cycle, without waiting for a clock edge: `mode_o` = 2'b00, `out_en_o` = 0, `lock_o` = 0 and `ref_fail_o` = 0. The mode encoding is 2'b00 start-up hold, 2'b01 freerun, 2'b10 tracking.
- R2: After `rst_n` rises, `mode_o` stays 2'b00 for HOLD_CYCLES + 1 clock edges. It becomes 2'b01 on edge HOLD_CYCLES + 2, where 2 edges are for the reset synchronizer. HOLD_CYCLES defaults to 60,000, which is 3 ms at 20 MHz.
- R3: A new low pulse on `rst_n` during the hold restarts the hold count, so the full count is needed again after the next release.
- R4: `out_en_o` is low exactly while `mode_o` is 2'b00 and high in freerun and tracking.
- R5: The start-up hold always exits to freerun. On the next edge the block moves to tracking if the synchronized reference-fail flag is low.
- R6: `ref_fail_o` follows `ref_fail_in` 2 edges after it changes. A rising `ref_fail_in` moves tracking to freerun on the 3rd edge.
- R7: A falling `ref_fail_in` moves freerun back to tracking on the 3rd edge.
- R8: `lock_o` is low whenever `mode_o` is not 2'b10, including from the first cycle after tracking is left.
- R9: In tracking, `lock_o` rises LOCK_QUAL + 2 edges after `lock_raw_in` rises. A raw-lock pulse shorter than LOCK_QUAL cycles never raises `lock_o`.
- R10: `lock_o` falls 3 edges after `lock_raw_in` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_fail_in | input | 1 | Reference-fail flag from the reference monitor (asynchronous) |
| lock_raw_in | input | 1 | Unqualified lock flag from the phase detector (asynchronous) |
| mode_o | output | 2 | Mode: 00 start-up hold, 01 freerun, 10 tracking |
| out_en_o | output | 1 | Enable for the external clock and frame-pulse tri-state drivers |
| lock_o | output | 1 | Qualified lock indicator |
| ref_fail_o | output | 1 | Synchronized reference-fail indicator |

## Verification
Each result is due a fixed number of edges after its stimulus:
- `ref_fail_o` is due 2 edges after `ref_fail_in` changes.
- The mode change follows on the 3rd edge.
- `lock_o` rises on edge LOCK_QUAL + 2 after `lock_raw_in` rises, and falls on the 3rd edge after it falls.
- Freerun begins on edge HOLD_CYCLES + 2 after the reset release.

Every task drives its inputs on a falling clock edge and counts rising edges from there. It samples 1 ns after the rising edge where the result is due, and also one edge earlier, so that both an early and a late change are caught. Reset assertion is checked in the middle of a clock period, to show that the outputs react without a clock edge.

// File: rtl/pll_mode_pkg.sv
// Package: shared mode encoding for the clock synchronizer mode sequencer.
// Assumes: the 2-bit encoding is decoded by neighbouring blocks as written here.
package pll_mode_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD     = 2'b00,
        MODE_FREERUN  = 2'b01,
        MODE_TRACKING = 2'b10
    } pll_mode_t;

endpackage

// File: rtl/pmc_rst_sync.sv
// Module: reset synchronizer with asynchronous assertion and synchronous release.
// Assumes: rst_n may change at any time relative to clk; STAGES >= 2.
module pmc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);

    logic [STAGES-1:0] chain_q;

    // Purpose: clear the chain at once on reset, fill it with ones after release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pmc_bit_sync.sv
// Module: multi-flop synchronizer for one level signal.
// Assumes: the input is a slow level and not a pulse; synchronous active-low reset.
module pmc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] sh_q;

    // Purpose: shift the asynchronous level through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = sh_q[STAGES-1];

endmodule

// File: rtl/pmc_mode_fsm.sv
// Module: mode state machine with the timed start-up hold.
// Assumes: rst_n is already synchronized to clk and ref_fail_s is synchronized.
// The hold counter is cleared by every reset, so each release needs the full count.
module pmc_mode_fsm
    import pll_mode_pkg::*;
#(
    parameter int HOLD_CYCLES = 60000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_fail_s,
    output pll_mode_t state_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

    pll_mode_t     state_q, state_d;
    logic [CW-1:0] hold_cnt_q;

    // Purpose: count master-clock cycles spent in the start-up hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt_q <= '0;
        end else if (state_q == MODE_HOLD && hold_cnt_q != HOLD_LAST) begin
            hold_cnt_q <= hold_cnt_q + 1'b1;
        end
    end

    // Purpose: choose the next mode from the hold count and the reference-fail flag.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HOLD:     if (hold_cnt_q == HOLD_LAST) state_d = MODE_FREERUN;
            MODE_FREERUN:  if (!ref_fail_s) state_d = MODE_TRACKING;
            MODE_TRACKING: if (ref_fail_s) state_d = MODE_FREERUN;
            default:       state_d = MODE_HOLD;
        endcase
    end

    // Purpose: mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R2: the hold is not left before the count completes.
    a_r2_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HOLD && hold_cnt_q != HOLD_LAST) |=> (state_q == MODE_HOLD));

    // R5: the hold always exits to freerun, never straight to tracking.
    a_r5_hold_to_freerun: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HOLD) |=> (state_q != MODE_TRACKING));

    // R6: a failed reference forces tracking back to freerun.
    a_r6_fail_leaves_tracking: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_TRACKING && ref_fail_s) |=> (state_q == MODE_FREERUN));

    // R7: a healthy reference brings freerun back to tracking.
    a_r7_clear_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_FREERUN && !ref_fail_s) |=> (state_q == MODE_TRACKING));

    // R2: the start-up hold is never re-entered without a reset.
    a_r2_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MODE_HOLD) |=> (state_q != MODE_HOLD));

endmodule

// File: rtl/pmc_lock_qual.sv
// Module: lock qualifier; raises the lock flag after a steady run of raw lock.
// Assumes: lock_s is synchronized; enable is high only in the tracking mode.
module pmc_lock_qual #(
    parameter int LOCK_QUAL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic lock_s,
    output logic lock_q_o
);

    localparam int QW = $clog2(LOCK_QUAL + 1);
    localparam logic [QW-1:0] QUAL_FULL = QW'(LOCK_QUAL);
    localparam logic [QW-1:0] QUAL_LAST = QW'(LOCK_QUAL - 1);

    logic [QW-1:0] run_q;
    logic          lock_q;

    // Purpose: count consecutive raw-lock cycles in tracking, saturating at LOCK_QUAL.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !lock_s) begin
            run_q <= '0;
        end else if (run_q != QUAL_FULL) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Purpose: qualified lock flag, set once the run has reached LOCK_QUAL.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !lock_s) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= (run_q >= QUAL_LAST);
        end
    end

    assign lock_q_o = lock_q;

    // R10: losing raw lock clears the qualified flag on the next edge.
    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_s) |=> (!lock_q));

    // R8: the flag cannot be set outside tracking.
    a_r8_needs_tracking: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (!lock_q));

    // R9: the flag is only ever held with a full run behind it.
    a_r9_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> (run_q == QUAL_FULL));

endmodule

// File: rtl/pll_mode_ctrl.sv
// Module: top of the clock synchronizer mode sequencer.
// Synchronizes the reset release and the two status flags, runs the mode
// state machine and the lock qualifier, and gates all outputs with the
// synchronized reset, so that a reset assertion shows at the outputs at once.
// Assumes: clk is the 20 MHz master clock; the tri-state buffers sit outside.
module pll_mode_ctrl
    import pll_mode_pkg::*;
#(
    parameter int HOLD_CYCLES = 60000,
    parameter int LOCK_QUAL   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_fail_in,
    input  logic       lock_raw_in,
    output logic [1:0] mode_o,
    output logic       out_en_o,
    output logic       lock_o,
    output logic       ref_fail_o
);

    localparam int NFLAGS = 2;

    logic              rst_s_n;
    logic [NFLAGS-1:0] flags_raw;
    logic [NFLAGS-1:0] flags_s;
    logic              ref_fail_s;
    logic              lock_s;
    logic              lock_q;
    logic              tracking;
    pll_mode_t         state;

    // Purpose: asynchronous assertion, synchronous release of the reset.
    pmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (rst_s_n)
    );

    assign flags_raw = {lock_raw_in, ref_fail_in};

    // One synchronizer for each incoming status flag.
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag_sync
        pmc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_s_n),
            .d_in  (flags_raw[g]),
            .q_out (flags_s[g])
        );
    end

    assign ref_fail_s = flags_s[0];
    assign lock_s     = flags_s[1];

    pmc_mode_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_s_n),
        .ref_fail_s (ref_fail_s),
        .state_o    (state)
    );

    assign tracking = (state == MODE_TRACKING);

    pmc_lock_qual #(.LOCK_QUAL(LOCK_QUAL)) u_lock (
        .clk      (clk),
        .rst_n    (rst_s_n),
        .enable   (tracking),
        .lock_s   (lock_s),
        .lock_q_o (lock_q)
    );

    // Purpose: output gating; reset and mode act on the outputs without a clock edge.
    always_comb begin
        mode_o     = rst_s_n ? state : MODE_HOLD;
        out_en_o   = rst_s_n && (state != MODE_HOLD);
        lock_o     = rst_s_n && tracking && lock_q;
        ref_fail_o = rst_s_n && ref_fail_s;
    end

    // R8: a qualified lock is only reported with the drivers enabled.
    a_r8_lock_enabled: assert property (@(posedge clk) disable iff (!rst_s_n)
        lock_o |-> out_en_o);

endmodule

// File: tb/pll_mode_ctrl_bench.sv
module pll_mode_ctrl_bench;

    localparam int HOLD = 200;
    localparam int QUAL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_fail_in = 1'b0;
    logic       lock_raw_in = 1'b0;
    logic [1:0] mode_o;
    logic       out_en_o, lock_o, ref_fail_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pll_mode_ctrl #(.HOLD_CYCLES(HOLD), .LOCK_QUAL(QUAL)) u_pll_mode_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_fail_in (ref_fail_in),
        .lock_raw_in (lock_raw_in),
        .mode_o      (mode_o),
        .out_en_o    (out_en_o),
        .lock_o      (lock_o),
        .ref_fail_o  (ref_fail_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        ref_fail_in = 1'b1;
        lock_raw_in = 1'b1;
        edges(5);
        check(mode_o == 2'b00, "R1 mode", mode_o, 0);
        check(out_en_o == 1'b0, "R1 out_en", out_en_o, 0);
        check(lock_o == 1'b0, "R1 lock", lock_o, 0);
        check(ref_fail_o == 1'b0, "R1 ref_fail", ref_fail_o, 0);
        @(negedge clk);
        ref_fail_in = 1'b0;
        lock_raw_in = 1'b0;
    endtask

    task automatic t_release_hold();
        @(negedge clk);
        rst_n = 1'b1;
        edges(HOLD + 1);
        check(mode_o == 2'b00, "R2 still hold", mode_o, 0);
        check(out_en_o == 1'b0, "R4 off in hold", out_en_o, 0);
        edges(1);
        check(mode_o == 2'b01, "R2 freerun", mode_o, 1);
        check(out_en_o == 1'b1, "R4 on in freerun", out_en_o, 1);
        edges(1);
        check(mode_o == 2'b10, "R5 tracking", mode_o, 2);
        check(out_en_o == 1'b1, "R4 on in tracking", out_en_o, 1);
    endtask

    task automatic t_ref_fail();
        @(negedge clk);
        ref_fail_in = 1'b1;
        edges(1);
        check(ref_fail_o == 1'b0, "R6 flag early", ref_fail_o, 0);
        edges(1);
        check(ref_fail_o == 1'b1, "R6 flag", ref_fail_o, 1);
        check(mode_o == 2'b10, "R6 mode early", mode_o, 2);
        edges(1);
        check(mode_o == 2'b01, "R6 freerun", mode_o, 1);
        edges(10);
        check(mode_o == 2'b01, "R6 stays freerun", mode_o, 1);
        @(negedge clk);
        ref_fail_in = 1'b0;
        edges(2);
        check(ref_fail_o == 1'b0, "R7 flag clear", ref_fail_o, 0);
        check(mode_o == 2'b01, "R7 mode early", mode_o, 1);
        edges(1);
        check(mode_o == 2'b10, "R7 tracking", mode_o, 2);
    endtask

    task automatic t_lock_qual();
        @(negedge clk);
        lock_raw_in = 1'b1;
        edges(QUAL + 1);
        check(lock_o == 1'b0, "R9 lock early", lock_o, 0);
        edges(1);
        check(lock_o == 1'b1, "R9 lock", lock_o, 1);
        @(negedge clk);
        lock_raw_in = 1'b0;
        edges(2);
        check(lock_o == 1'b1, "R10 lock held", lock_o, 1);
        edges(1);
        check(lock_o == 1'b0, "R10 lock drop", lock_o, 0);
    endtask

    task automatic t_lock_glitch();
        bit seen = 1'b0;
        @(negedge clk);
        lock_raw_in = 1'b1;
        repeat (QUAL - 1) @(negedge clk);
        lock_raw_in = 1'b0;
        for (int i = 0; i < QUAL + 6; i++) begin
            edges(1);
            if (lock_o) seen = 1'b1;
        end
        check(!seen, "R9 short pulse", seen, 0);
    endtask

    task automatic t_lock_freerun();
        @(negedge clk);
        lock_raw_in = 1'b1;
        edges(QUAL + 2);
        check(lock_o == 1'b1, "R9 relock", lock_o, 1);
        @(negedge clk);
        ref_fail_in = 1'b1;
        edges(2);
        check(lock_o == 1'b1, "R8 lock before leave", lock_o, 1);
        edges(1);
        check(lock_o == 1'b0, "R8 lock off on leave", lock_o, 0);
        edges(20);
        check(lock_o == 1'b0, "R8 lock off in freerun", lock_o, 0);
        @(negedge clk);
        ref_fail_in = 1'b0;
        edges(3);
        check(mode_o == 2'b10 && lock_o == 1'b0, "R8 back, not locked", lock_o, 0);
        edges(QUAL - 1);
        check(lock_o == 1'b0, "R9 requal early", lock_o, 0);
        edges(1);
        check(lock_o == 1'b1, "R9 requal", lock_o, 1);
    endtask

    task automatic t_async_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        check(mode_o == 2'b00, "R1 async mode", mode_o, 0);
        check(out_en_o == 1'b0, "R1 async out_en", out_en_o, 0);
        check(lock_o == 1'b0, "R1 async lock", lock_o, 0);
        lock_raw_in = 1'b0;
        edges(3);
    endtask

    task automatic t_restart();
        @(negedge clk);
        rst_n = 1'b1;
        edges(100);
        check(mode_o == 2'b00, "R3 mid hold", mode_o, 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        edges(HOLD + 1);
        check(mode_o == 2'b00, "R3 restarted hold", mode_o, 0);
        edges(1);
        check(mode_o == 2'b01, "R3 freerun after full hold", mode_o, 1);
    endtask

    initial begin
        t_reset_state();
        t_release_hold();
        t_ref_fail();
        t_lock_qual();
        t_lock_glitch();
        t_lock_freerun();
        t_async_reset();
        t_restart();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule